// File: doc/BRIEF.md
# Threshold-Start Transmit Frame Buffer

This block stages outgoing frame data between a memory-side DMA engine and a MAC transmit FIFO. The memory side offers 32-bit words, each marked with an end-of-frame flag, over a valid/ready handshake. The words are kept in a 64-word circular store. The block pushes them one per cycle into the MAC FIFO and stalls whenever that FIFO reports full.

A new frame is not released at once. It waits until the store holds a chosen fraction of its capacity. The fraction is set by a 3-bit start-level code in steps of one eighth, up to one half. The wait ends early as soon as the frame's last word is already in the store. Once a frame has started, it runs to its end-of-frame word.

An enable flag gates intake from memory. It is set or cleared by a write strobe, and an ownership-lost input clears it. When the flag is off, the words already stored still drain to the MAC FIFO. A soft-reset pulse empties the store and returns the block to idle. An optional byte swap reverses the byte order of each word as it leaves. The end-of-frame flag travels with the word into the MAC FIFO.

Top module: `tx_frame_stager`

## Requirements
- R1: After `rst_n` is asserted, `tx_en` is 0, `fill_count` is 0, `in_ready` is 0 and `mac_push` is 0.
- R2: An `en_wr` pulse loads `en_wdata` into `tx_en` on the next cycle. While `tx_en` is 1 and `fill_count` is below 64, `in_ready` is 1. Intake stops at exactly 64 stored words.
- R3: For a frame whose first word is at the head of the store, forwarding begins in the first cycle in which `fill_count` is at least 8×n, where n is the `start_lvl` code 0..4. Code 0 starts as soon as one word is stored, and codes 5, 6 and 7 act as code 4, which is 32 words. Forwarding begins with `mac_push` high in that same cycle when `mac_full` is 0.
- R4: If the store holds a word whose end-of-frame flag is set, the frame at the head starts forwarding whatever the start level.
- R5: Once a frame has started, one word is pushed each cycle in which the store is not empty and `mac_full` is 0, until its end-of-frame word is pushed. The next frame then waits for its own start condition again. No push happens while `fill_count` is 0.
- R6: No word is pushed while `mac_full` is 1. Held words are later pushed in the order they were written.
- R7: With `swap_en` at 1, `mac_data[31:24]`, `[23:16]`, `[15:8]` and `[7:0]` carry input bytes `[7:0]`, `[15:8]`, `[23:16]` and `[31:24]`. With `swap_en` at 0 the word is unchanged. `mac_eof` equals the end-of-frame flag written with the word.
- R8: Once `tx_en` is 0, `in_ready` is 0. Every stored word is still pushed until the store is empty, including a partial frame below its start level.
- R9: A cycle with `soft_rst` high leaves `fill_count` at 0 and `tx_en` at 0 on the next cycle. Words stored before it are never pushed.
- R10: `own_lost` high clears `tx_en` on the next cycle, even when an `en_wr` pulse setting it arrives in the same cycle.
- R11: `fill_count` equals the words accepted (`in_valid` and `in_ready` both high) minus the words pushed since the last reset or soft reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous flush of the store and return to idle |
| en_wr | input | 1 | Write strobe for the enable flag |
| en_wdata | input | 1 | Value loaded into the enable flag on `en_wr` |
| own_lost | input | 1 | Buffer ownership lost; clears the enable flag |
| start_lvl | input | 3 | Start-level code in eighths of capacity (5..7 act as 4) |
| swap_en | input | 1 | Reverse the byte order of outgoing words |
| tx_en | output | 1 | Current enable flag |
| in_valid | input | 1 | Memory side offers a word |
| in_data | input | DATA_W (32) | Offered word |
| in_eof | input | 1 | Offered word is the last of its frame |
| in_ready | output | 1 | Block accepts the offered word this cycle |
| mac_full | input | 1 | MAC transmit FIFO cannot take a word |
| mac_push | output | 1 | Word written into the MAC FIFO this cycle |
| mac_data | output | DATA_W (32) | Word towards the MAC FIFO |
| mac_eof | output | 1 | End-of-frame flag towards the MAC FIFO |
| fill_count | output | $clog2(DEPTH+1) (7) | Number of words currently stored |

## Verification
Intake of a new word and a push to the MAC FIFO often land in the same cycle. This happens while a frame streams out and the memory side keeps writing. The bench provokes it by writing words back to back after a frame's start threshold has been crossed. It then judges the outcome by comparing the full output sequence, with bytes and flags, against the words it wrote, and by checking `fill_count` for a net of accepted minus pushed words. The bench also drives `own_lost` together with an `en_wr` pulse that sets the flag, and requires `tx_en` to read 0 afterwards.

// File: rtl/tfs_pkg.sv
package tfs_pkg;
    // largest start-level code honoured; higher codes clamp to it
    localparam logic [2:0] LVL_CLAMP = 3'd4;
    // the start level counts in this fraction of the store depth
    localparam int LVL_DIV = 8;

    typedef enum logic {
        GATE_HELD = 1'b0,
        GATE_SEND = 1'b1
    } gate_e;
endpackage

// File: rtl/tfs_store.sv
module tfs_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_eof,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_eof,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  eof_cnt,
    output logic              full
);
    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] eofs;
    } store_t;

    store_t st_d, st_q;
    logic [DATA_W:0] mem [DEPTH];
    logic [DATA_W:0] head;

    assign head    = mem[st_q.rptr];
    assign rd_data = head[DATA_W-1:0];
    assign rd_eof  = head[DATA_W];
    assign count   = st_q.count;
    assign eof_cnt = st_q.eofs;
    assign full    = (st_q.count == CNT_W'(DEPTH));

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (wr_en) begin
                st_d.wptr = st_q.wptr + PTR_W'(1);
            end
            if (rd_en) begin
                st_d.rptr = st_q.rptr + PTR_W'(1);
            end
            if (wr_en && !rd_en) begin
                st_d.count = st_q.count + CNT_W'(1);
            end else if (rd_en && !wr_en) begin
                st_d.count = st_q.count - CNT_W'(1);
            end
            if ((wr_en && wr_eof) && !(rd_en && rd_eof)) begin
                st_d.eofs = st_q.eofs + CNT_W'(1);
            end else if (!(wr_en && wr_eof) && (rd_en && rd_eof)) begin
                st_d.eofs = st_q.eofs - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[st_q.wptr] <= {wr_eof, wr_data};
        end
    end
endmodule

// File: rtl/tfs_gate.sv
module tfs_gate
    import tfs_pkg::*;
#(
    parameter int DEPTH  = 64,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int STEP  = DEPTH / LVL_DIV
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             enabled,
    input  logic [2:0]       start_lvl,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] eof_cnt,
    input  logic             head_eof,
    input  logic             mac_full,
    output logic             pop
);
    typedef struct packed {
        gate_e mode;
    } gate_t;

    gate_t gt_d, gt_q;
    logic [2:0]       lvl_eff;
    logic [CNT_W-1:0] thr;
    logic             have_word;
    logic             start_ok;
    logic             active;

    always_comb begin
        lvl_eff   = (start_lvl > LVL_CLAMP) ? LVL_CLAMP : start_lvl;
        thr       = CNT_W'(lvl_eff) * CNT_W'(STEP);
        have_word = (count != '0);
        // a held frame may start on threshold, a complete frame, or drain
        start_ok  = have_word && ((eof_cnt != '0) || (count >= thr) || !enabled);
        active    = (gt_q.mode == GATE_SEND) || start_ok;
        pop       = active && have_word && !mac_full && !flush;

        gt_d = gt_q;
        if (flush) begin
            gt_d.mode = GATE_HELD;
        end else if (pop && head_eof) begin
            gt_d.mode = GATE_HELD;
        end else if (active) begin
            gt_d.mode = GATE_SEND;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gt_q <= '{mode: GATE_HELD};
        end else begin
            gt_q <= gt_d;
        end
    end
endmodule

// File: rtl/tfs_swap.sv
module tfs_swap #(
    parameter int DATA_W = 32,
    localparam int NB    = DATA_W / 8
) (
    input  logic              swap_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] rev;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign rev[g*8 +: 8] = din[(NB-1-g)*8 +: 8];
    end

    assign dout = swap_en ? rev : din;
endmodule

// File: rtl/tx_frame_stager.sv
module tx_frame_stager #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              en_wr,
    input  logic              en_wdata,
    input  logic              own_lost,
    input  logic [2:0]        start_lvl,
    input  logic              swap_en,
    output logic              tx_en,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_eof,
    output logic              in_ready,
    input  logic              mac_full,
    output logic              mac_push,
    output logic [DATA_W-1:0] mac_data,
    output logic              mac_eof,
    output logic [CNT_W-1:0]  fill_count
);
    typedef struct packed {
        logic en;
    } ctl_t;

    ctl_t ct_d, ct_q;
    logic              store_full;
    logic              wr_fire;
    logic              rd_fire;
    logic [DATA_W-1:0] head_data;
    logic              head_eof;
    logic [CNT_W-1:0]  eof_cnt;

    always_comb begin
        ct_d = ct_q;
        if (soft_rst || own_lost) begin
            ct_d.en = 1'b0;
        end else if (en_wr) begin
            ct_d.en = en_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ct_q <= '0;
        end else begin
            ct_q <= ct_d;
        end
    end

    assign tx_en    = ct_q.en;
    assign in_ready = ct_q.en && !store_full && !soft_rst;
    assign wr_fire  = in_valid && in_ready;
    assign mac_push = rd_fire;
    assign mac_eof  = head_eof;

    tfs_store #(
        .DATA_W(DATA_W),
        .DEPTH (DEPTH)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (soft_rst),
        .wr_en  (wr_fire),
        .wr_data(in_data),
        .wr_eof (in_eof),
        .rd_en  (rd_fire),
        .rd_data(head_data),
        .rd_eof (head_eof),
        .count  (fill_count),
        .eof_cnt(eof_cnt),
        .full   (store_full)
    );

    tfs_gate #(
        .DEPTH(DEPTH)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (soft_rst),
        .enabled  (ct_q.en),
        .start_lvl(start_lvl),
        .count    (fill_count),
        .eof_cnt  (eof_cnt),
        .head_eof (head_eof),
        .mac_full (mac_full),
        .pop      (rd_fire)
    );

    tfs_swap #(
        .DATA_W(DATA_W)
    ) u_swap (
        .swap_en(swap_en),
        .din    (head_data),
        .dout   (mac_data)
    );
endmodule

// File: rtl/tfs_checker.sv
module tfs_checker #(
    parameter int DEPTH  = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             soft_rst,
    input logic             own_lost,
    input logic             tx_en,
    input logic             in_valid,
    input logic             in_ready,
    input logic             mac_full,
    input logic             mac_push,
    input logic [CNT_W-1:0] fill_count
);
    logic acc;
    assign acc = in_valid && in_ready;

    a_r6_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        mac_full |-> !mac_push);

    a_r8_no_intake_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !in_ready);

    a_r2_fill_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= CNT_W'(DEPTH));

    a_r5_no_push_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count == '0) |-> !mac_push);

    a_r9_soft_reset_empties: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> ((fill_count == '0) && !tx_en));

    a_r10_owner_lost_clears: assert property (@(posedge clk) disable iff (!rst_n)
        own_lost |=> !tx_en);

    a_r11_fill_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst |=> (fill_count ==
            $past(fill_count) + CNT_W'($past(acc)) - CNT_W'($past(mac_push))));
endmodule

bind tx_frame_stager tfs_checker #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .own_lost  (own_lost),
    .tx_en     (tx_en),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .mac_full  (mac_full),
    .mac_push  (mac_push),
    .fill_count(fill_count)
);

// File: tb/tx_frame_stager_bench.sv
`timescale 1ns/1ps
module tx_frame_stager_bench;
    localparam int DW = 32;
    localparam int DP = 64;
    localparam int CW = $clog2(DP + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 1'b0, en_wr = 1'b0, en_wdata = 1'b0, own_lost = 1'b0;
    logic [2:0] start_lvl = 3'd0;
    logic swap_en = 1'b0;
    logic tx_en;
    logic in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic in_eof = 1'b0;
    logic in_ready;
    logic mac_full = 1'b0;
    logic mac_push;
    logic [DW-1:0] mac_data;
    logic mac_eof;
    logic [CW-1:0] fill_count;

    tx_frame_stager #(.DATA_W(DW), .DEPTH(DP)) u_tx_frame_stager (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .en_wr(en_wr),
        .en_wdata(en_wdata), .own_lost(own_lost), .start_lvl(start_lvl),
        .swap_en(swap_en), .tx_en(tx_en), .in_valid(in_valid),
        .in_data(in_data), .in_eof(in_eof), .in_ready(in_ready),
        .mac_full(mac_full), .mac_push(mac_push), .mac_data(mac_data),
        .mac_eof(mac_eof), .fill_count(fill_count)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [DW-1:0] exp_d [256];
    logic          exp_e [256];
    logic [DW-1:0] got_d [256];
    logic          got_e [256];
    int exp_n = 0;
    int got_n = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (mac_push && got_n < 256) begin
            got_d[got_n] = mac_data;
            got_e[got_n] = mac_eof;
            got_n++;
        end
    end

    function automatic logic [DW-1:0] bswap(input logic [DW-1:0] d, input logic s);
        return s ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic write_word(input logic [DW-1:0] d, input logic e);
        in_valid = 1'b1;
        in_data  = d;
        in_eof   = e;
        @(negedge clk);
        if (in_ready && exp_n < 256) begin
            exp_d[exp_n] = bswap(d, swap_en);
            exp_e[exp_n] = e;
            exp_n++;
        end
        tick();
        in_valid = 1'b0;
        in_eof   = 1'b0;
    endtask

    task automatic set_enable(input logic v);
        en_wr = 1'b1;
        en_wdata = v;
        tick();
        en_wr = 1'b0;
    endtask

    task automatic restart();
        soft_rst = 1'b1;
        tick();
        soft_rst = 1'b0;
        exp_n = 0;
        got_n = 0;
        set_enable(1'b1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic compare_stream(input string tag);
        check(got_n == exp_n, {tag, " word count"}, got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            check(got_d[i] == exp_d[i], {tag, " data"}, got_d[i], exp_d[i]);
            check(got_e[i] == exp_e[i], {tag, " eof flag"}, got_e[i], exp_e[i]);
        end
    endtask

    initial begin
        int first;
        int acc;
        idle(3);
        @(negedge clk);
        check(tx_en == 1'b0, "R1 tx_en after reset", tx_en, 0);
        check(fill_count == '0, "R1 fill after reset", fill_count, 0);
        check(in_ready == 1'b0, "R1 in_ready after reset", in_ready, 0);
        check(mac_push == 1'b0, "R1 push after reset", mac_push, 0);
        rst_n = 1'b1;
        tick();

        set_enable(1'b1);
        @(negedge clk);
        check(tx_en == 1'b1, "R2 enable write", tx_en, 1);
        check(in_ready == 1'b1, "R2 ready when enabled", in_ready, 1);
        tick();

        // R3 sweep of every start-level code, R7 swap alternated per code
        for (int c = 0; c < 8; c++) begin
            start_lvl = 3'(c);
            swap_en = c[0];
            restart();
            first = (c == 0) ? 1 : 8 * ((c > 4) ? 4 : c);
            for (int k = 1; k < first; k++) write_word(32'h0100_0000 * c + 32'h0001_0203 * k, 1'b0);
            idle(3);
            check(got_n == 0, "R3 held below threshold", got_n, 0);
            check(fill_count == CW'(first - 1), "R11 fill below threshold", fill_count, first - 1);
            write_word(32'h0100_0000 * c + 32'h0001_0203 * first, 1'b0);
            @(negedge clk);
            check(mac_push == 1'b1, "R3 start at threshold", mac_push, 1);
            tick();
            for (int k = 1; k <= 3; k++) write_word(32'hA5A5_0000 + k, k == 3);
            idle(60);
            compare_stream("R3 R7 sweep");
            check(fill_count == '0, "R11 empty after frame", fill_count, 0);
        end

        // R4 complete short frame overrides a half-full start level
        start_lvl = 3'd4;
        swap_en = 1'b0;
        restart();
        write_word(32'h1111_0001, 1'b0);
        write_word(32'h1111_0002, 1'b0);
        idle(3);
        check(got_n == 0, "R4 held before eof", got_n, 0);
        write_word(32'h1111_0003, 1'b1);
        @(negedge clk);
        check(mac_push == 1'b1, "R4 start on eof", mac_push, 1);
        idle(10);
        compare_stream("R4 frame");

        // R5 frame runs to eof, next frame waits its own threshold
        start_lvl = 3'd1;
        restart();
        for (int k = 0; k < 10; k++) write_word(32'h2222_0000 + k, k == 9);
        idle(20);
        check(got_n == 10, "R5 first frame done", got_n, 10);
        for (int k = 0; k < 5; k++) write_word(32'h3333_0000 + k, 1'b0);
        idle(5);
        check(got_n == 10, "R5 second frame held", got_n, 10);
        for (int k = 5; k < 8; k++) write_word(32'h3333_0000 + k, 1'b0);
        @(negedge clk);
        check(mac_push == 1'b1, "R5 second frame starts", mac_push, 1);
        tick();
        write_word(32'h3333_00FF, 1'b1);
        idle(20);
        compare_stream("R5 frames");

        // R6 stall on full MAC FIFO
        start_lvl = 3'd0;
        swap_en = 1'b1;
        mac_full = 1'b1;
        restart();
        for (int k = 0; k < 4; k++) write_word(32'h4455_6677 + 32'h0101_0101 * k, k == 3);
        idle(6);
        check(got_n == 0, "R6 no push while full", got_n, 0);
        check(fill_count == CW'(4), "R6 words held", fill_count, 4);
        mac_full = 1'b0;
        idle(10);
        compare_stream("R6 release");

        // R2 capacity, then R9 soft reset discards stored words
        start_lvl = 3'd4;
        swap_en = 1'b0;
        mac_full = 1'b1;
        restart();
        acc = 0;
        in_valid = 1'b1;
        for (int k = 0; k < 70; k++) begin
            in_data = 32'h5000_0000 + k;
            @(negedge clk);
            if (in_ready) acc++;
            tick();
        end
        in_valid = 1'b0;
        @(negedge clk);
        check(acc == 64, "R2 intake count", acc, 64);
        check(fill_count == CW'(64), "R2 fill at capacity", fill_count, 64);
        check(in_ready == 1'b0, "R2 not ready when full", in_ready, 0);
        tick();
        soft_rst = 1'b1;
        tick();
        soft_rst = 1'b0;
        @(negedge clk);
        check(fill_count == '0, "R9 fill cleared", fill_count, 0);
        check(tx_en == 1'b0, "R9 enable cleared", tx_en, 0);
        tick();
        mac_full = 1'b0;
        idle(10);
        check(got_n == 0, "R9 old words dropped", got_n, 0);

        // R8 disable drains a partial frame below threshold
        start_lvl = 3'd4;
        restart();
        for (int k = 0; k < 5; k++) write_word(32'h6000_0000 + k, 1'b0);
        idle(3);
        check(got_n == 0, "R8 held while enabled", got_n, 0);
        set_enable(1'b0);
        @(negedge clk);
        check(tx_en == 1'b0, "R8 enable cleared", tx_en, 0);
        check(in_ready == 1'b0, "R8 intake stopped", in_ready, 0);
        idle(10);
        compare_stream("R8 drain");
        check(fill_count == '0, "R8 drained empty", fill_count, 0);

        // R10 ownership loss beats a simultaneous enable write
        set_enable(1'b1);
        own_lost = 1'b1;
        en_wr = 1'b1;
        en_wdata = 1'b1;
        tick();
        own_lost = 1'b0;
        en_wr = 1'b0;
        @(negedge clk);
        check(tx_en == 1'b0, "R10 owner lost clears enable", tx_en, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule